// File: doc/BRIEF.md
# I2C Master Status and Interrupt Unit

This unit keeps the status-side registers of an I2C master controller: a status register, an extended status register, an interrupt-cause mask, a mode register, an extended control register and a direct line-control register. The transfer sequencer and the data buffer report to it through single-cycle event pulses (transfer started, transfer done with its byte count, aborted, halted, slave transfer) and through level inputs (buffer fill level, bus busy). From these the unit keeps sticky status flags and drives one level-sensitive interrupt line.

Software reaches the registers through byte-wide write strobes and a combinational read port that share one address. Some flags clear when software writes a one to them. A write that sets the soft-reset bit returns the controller state to its reset values and sends a one-cycle pulse to the rest of the controller.

Register offsets: 0 status, 1 extended status, 2 interrupt mask, 3 mode, 4 extended control, 5 line control. Other offsets read zero and ignore writes.

Top module: `i2c_stat_irq`

## Requirements
- R1: After reset: status reads 0x00, extended status reads 0x40 while the bus is idle, mask 0x00, mode 0x00, extended control 0x00, line control 0x0F, and `irq` and `softResetPulse` are low.
- R2: Status bit0 (transfer pending) is set by `evStart` and cleared by `evDone`, `evAbort` or `evHalt`. Status bit2 (error) is set by `evAbort` and cleared by `evStart`. Extended status bit0 latches `evAbort` and bit1 latches `evHalt`. When a set and a clear of the same flag arrive in one cycle, the set wins.
- R3: Status bit4 reads 1 when `bufLevel` equals the buffer depth (4). Status bit5 reads 1 when `bufLevel` is non-zero. Both follow the input in the same cycle.
- R4: Mask bits map to causes as follows: bit0 transfer done, bit1 abort, bit2 slave transfer, bit3 halt. A cause raises `irq` and sets status bit1 on the next edge, but only when mode bit2 (global enable) is 1 and its mask bit is 1.
- R5: An `evDone` whose `doneBytes` is zero raises no interrupt.
- R6: A status write clears only bits 1 and 3, and only where the written bit is 1. Clearing bit1 lowers `irq` when mode bit2 is 1. When mode bit2 is 0, `irq` stays high.
- R7: An extended-status write clears the stored bits under mask 0x8F where the written bit is 1. Bit4 reads `busBusy` and bit6 reads its inverse, and writes do not change either.
- R8: The mode register stores only the bits under 0x3D of the written value. `slaveUnsupported` is high while mode bit3 is 1.
- R9: Extended control bits 7:4 are sticky flags set by `flagSet[3:0]`. A write clears the flags written as 1, and a simultaneous `flagSet` bit wins. A write with bit0 set resets status, extended status, mask, mode, line control and `irq` to their reset values on that edge, and pulses `softResetPulse` for the following cycle.
- R10: The line-control register stores written bits 3:0, and bits 7:4 read zero.
- R11: An interrupt cause in the same cycle as a status write clearing bit1 leaves `irq` and status bit1 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register byte write strobe |
| addr | input | ADDR_W | Register offset for read and write |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr` (combinational) |
| evStart | input | 1 | Transfer started pulse |
| evDone | input | 1 | Transfer finished pulse |
| doneBytes | input | CNT_W | Bytes moved by the finished transfer |
| evAbort | input | 1 | Transfer aborted pulse |
| evHalt | input | 1 | Halt executed pulse |
| evSlave | input | 1 | Slave transfer pulse |
| bufLevel | input | LVL_W | Data buffer fill level |
| busBusy | input | 1 | Bus busy level |
| flagSet | input | 4 | Sets extended control flags 7:4 |
| irq | output | 1 | Level interrupt |
| softResetPulse | output | 1 | One-cycle soft reset to the controller |
| slaveUnsupported | output | 1 | Slave mode was requested (unsupported) |

## Verification
The hardest state to reach is an interrupt line that stays high after its status bit is cleared. This needs a raised interrupt, then the global enable turned off, and only then the status clear. The directed sequence builds it in that order, then turns the enable back on and clears again. The same-edge races also need care: a cause arriving together with its clear, and a flag set arriving together with its write-one-to-clear. These are driven on purpose, and a long run of random traffic is compared every cycle against a behavioural model.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int REG_STAT  = 0;
  localparam int REG_XSTAT = 1;
  localparam int REG_MASK  = 2;
  localparam int REG_MODE  = 3;
  localparam int REG_XCTL  = 4;
  localparam int REG_LINE  = 5;
  localparam int NUM_REGS  = 6;

  localparam logic [7:0] MODE_KEEP = 8'h3D;
  localparam int MODE_GEN = 2;
  localparam int MODE_SLV = 3;
  localparam logic [3:0] LINE_RST = 4'hF;

  typedef struct packed {
    logic wrStat;
    logic wrXStat;
    logic wrMask;
    logic wrMode;
    logic wrXctl;
    logic wrLine;
    logic softRst;
    logic raiseIrq;
    logic setPend;
    logic clrPend;
    logic setErr;
    logic clrErr;
    logic setAbort;
    logic setHalt;
  } stat_strobes_t;
endpackage

// File: rtl/i2c_stat_ctrl.sv
module i2c_stat_ctrl
  import i2c_stat_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrBit0,
  input  logic              evStart,
  input  logic              evDone,
  input  logic [CNT_W-1:0]  doneBytes,
  input  logic              evAbort,
  input  logic              evHalt,
  input  logic              evSlave,
  input  logic [3:0]        intMask,
  input  logic              gEn,
  output stat_strobes_t     stb
);
  logic [NUM_REGS-1:0] sel;
  logic [3:0] cause;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    assign sel[i] = wrEn && (addr == ADDR_W'(i));
  end

  assign cause = {evHalt, evSlave, evAbort, evDone && (doneBytes != '0)};

  always_comb begin
    stb          = '0;
    stb.wrStat   = sel[REG_STAT];
    stb.wrXStat  = sel[REG_XSTAT];
    stb.wrMask   = sel[REG_MASK];
    stb.wrMode   = sel[REG_MODE];
    stb.wrXctl   = sel[REG_XCTL];
    stb.wrLine   = sel[REG_LINE];
    stb.softRst  = sel[REG_XCTL] && wrBit0;
    stb.raiseIrq = gEn && ((cause & intMask) != 4'b0);
    stb.setPend  = evStart;
    stb.clrPend  = evDone || evAbort || evHalt;
    stb.setErr   = evAbort;
    stb.clrErr   = evStart;
    stb.setAbort = evAbort;
    stb.setHalt  = evHalt;
  end

  // R5
  zero_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evDone && doneBytes == '0 && !evAbort && !evHalt && !evSlave) |-> !stb.raiseIrq);
endmodule

// File: rtl/i2c_stat_regs.sv
module i2c_stat_regs
  import i2c_stat_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int BUF_DEPTH = 4,
  parameter int LVL_W     = $clog2(BUF_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  stat_strobes_t     stb,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LVL_W-1:0]  bufLevel,
  input  logic              busBusy,
  input  logic [3:0]        flagSet,
  output logic [7:0]        rdData,
  output logic [3:0]        intMask,
  output logic              gEn,
  output logic              irq,
  output logic              softResetPulse,
  output logic              slaveUnsupported
);
  logic stPend, stIrq, stErr, xAbort, xHalt, irqQ, softPulse;
  logic [7:0] modeQ;
  logic [3:0] maskQ, flagsQ, lineQ;
  logic bufFull, bufAny;

  assign bufFull = (bufLevel == LVL_W'(BUF_DEPTH));
  assign bufAny  = (bufLevel != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stPend <= 1'b0; stIrq <= 1'b0; stErr <= 1'b0;
      xAbort <= 1'b0; xHalt <= 1'b0;
      maskQ <= '0; modeQ <= '0; lineQ <= LINE_RST;
      flagsQ <= '0; irqQ <= 1'b0; softPulse <= 1'b0;
    end else begin
      softPulse <= stb.softRst;
      flagsQ <= (stb.wrXctl ? (flagsQ & ~wrData[7:4]) : flagsQ) | flagSet;
      if (stb.softRst) begin
        stPend <= 1'b0; stIrq <= 1'b0; stErr <= 1'b0;
        xAbort <= 1'b0; xHalt <= 1'b0;
        maskQ <= '0; modeQ <= '0; lineQ <= LINE_RST;
        irqQ <= 1'b0;
      end else begin
        if (stb.setPend)      stPend <= 1'b1;
        else if (stb.clrPend) stPend <= 1'b0;
        if (stb.setErr)       stErr <= 1'b1;
        else if (stb.clrErr)  stErr <= 1'b0;
        if (stb.raiseIrq)                    stIrq <= 1'b1;
        else if (stb.wrStat && wrData[1])    stIrq <= 1'b0;
        if (stb.raiseIrq)                                  irqQ <= 1'b1;
        else if (stb.wrStat && wrData[1] && modeQ[MODE_GEN]) irqQ <= 1'b0;
        if (stb.setAbort)                    xAbort <= 1'b1;
        else if (stb.wrXStat && wrData[0])   xAbort <= 1'b0;
        if (stb.setHalt)                     xHalt <= 1'b1;
        else if (stb.wrXStat && wrData[1])   xHalt <= 1'b0;
        if (stb.wrMask) maskQ <= wrData[3:0];
        if (stb.wrMode) modeQ <= wrData & MODE_KEEP;
        if (stb.wrLine) lineQ <= wrData[3:0];
      end
    end
  end

  always_comb begin
    case (addr)
      ADDR_W'(REG_STAT):  rdData = {2'b00, bufAny, bufFull, 1'b0, stErr, stIrq, stPend};
      ADDR_W'(REG_XSTAT): rdData = {1'b0, ~busBusy, 1'b0, busBusy, 2'b00, xHalt, xAbort};
      ADDR_W'(REG_MASK):  rdData = {4'h0, maskQ};
      ADDR_W'(REG_MODE):  rdData = modeQ;
      ADDR_W'(REG_XCTL):  rdData = {flagsQ, 4'h0};
      ADDR_W'(REG_LINE):  rdData = {4'h0, lineQ};
      default:            rdData = 8'h00;
    endcase
  end

  assign intMask          = maskQ;
  assign gEn              = modeQ[MODE_GEN];
  assign irq              = irqQ;
  assign softResetPulse   = softPulse;
  assign slaveUnsupported = modeQ[MODE_SLV];

  // R4
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqQ) |-> stIrq);
  // R6
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrStat && wrData[1] && gEn && !stb.raiseIrq && !stb.softRst) |=> !irqQ);
  // R9
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.softRst |=> (softPulse && lineQ == LINE_RST && modeQ == 8'h00 && !irqQ));
  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.raiseIrq && !stb.softRst) |=> (irqQ && stIrq));
endmodule

// File: rtl/i2c_stat_irq.sv
module i2c_stat_irq
  import i2c_stat_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int BUF_DEPTH = 4,
  parameter int CNT_W     = 3,
  parameter int LVL_W     = $clog2(BUF_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic              evStart,
  input  logic              evDone,
  input  logic [CNT_W-1:0]  doneBytes,
  input  logic              evAbort,
  input  logic              evHalt,
  input  logic              evSlave,
  input  logic [LVL_W-1:0]  bufLevel,
  input  logic              busBusy,
  input  logic [3:0]        flagSet,
  output logic              irq,
  output logic              softResetPulse,
  output logic              slaveUnsupported
);
  stat_strobes_t stb;
  logic [3:0] intMask;
  logic gEn;

  i2c_stat_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrBit0(wrData[0]),
    .evStart(evStart), .evDone(evDone), .doneBytes(doneBytes),
    .evAbort(evAbort), .evHalt(evHalt), .evSlave(evSlave),
    .intMask(intMask), .gEn(gEn), .stb(stb)
  );

  i2c_stat_regs #(.ADDR_W(ADDR_W), .BUF_DEPTH(BUF_DEPTH), .LVL_W(LVL_W)) u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .addr(addr),
    .bufLevel(bufLevel), .busBusy(busBusy), .flagSet(flagSet),
    .rdData(rdData), .intMask(intMask), .gEn(gEn), .irq(irq),
    .softResetPulse(softResetPulse), .slaveUnsupported(slaveUnsupported)
  );
endmodule

// File: tb/i2c_stat_irq_test.sv
`timescale 1ns/100ps
module i2c_stat_irq_test;
  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [2:0] addr = '0, doneBytes = '0, bufLevel = '0;
  logic [7:0] wrData = '0, rdData;
  logic evStart = 0, evDone = 0, evAbort = 0, evHalt = 0, evSlave = 0, busBusy = 0;
  logic [3:0] flagSet = '0;
  logic irq, softResetPulse, slaveUnsupported;
  int checks = 0, errors = 0;
  bit finished = 0;

  // behavioural model state
  bit mPend, mIrqSt, mErr, mAb, mHa, mIrq, mPulse;
  int mMask, mMode, mFlags, mLine;

  always #2.5 clk = ~clk;

  i2c_stat_irq uut (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int modelRead(int a);
    case (a)
      0: return (bufLevel != 0 ? 32 : 0) + (bufLevel == 4 ? 16 : 0) + (mErr ? 4 : 0) + (mIrqSt ? 2 : 0) + (mPend ? 1 : 0);
      1: return (busBusy ? 16 : 64) + (mHa ? 2 : 0) + (mAb ? 1 : 0);
      2: return mMask;
      3: return mMode;
      4: return mFlags * 16;
      5: return mLine;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPend = 0; mIrqSt = 0; mErr = 0; mAb = 0; mHa = 0; mIrq = 0; mPulse = 0;
      mMask = 0; mMode = 0; mFlags = 0; mLine = 15;
    end else begin
      bit srst, raise, wS;
      srst = wrEn && addr == 4 && wrData[0];
      mPulse = srst;
      if (wrEn && addr == 4) mFlags = mFlags & ~int'(wrData[7:4]);
      mFlags = mFlags | int'(flagSet);
      if (srst) begin
        mPend = 0; mIrqSt = 0; mErr = 0; mAb = 0; mHa = 0; mIrq = 0;
        mMask = 0; mMode = 0; mLine = 15;
      end else begin
        raise = ((mMode & 4) != 0) &&
                ((evDone && doneBytes > 0 && (mMask & 1) != 0) || (evAbort && (mMask & 2) != 0) ||
                 (evSlave && (mMask & 4) != 0) || (evHalt && (mMask & 8) != 0));
        wS = wrEn && addr == 0 && wrData[1];
        if (wS && (mMode & 4) != 0) mIrq = 0;
        if (wS) mIrqSt = 0;
        if (raise) begin mIrq = 1; mIrqSt = 1; end
        if (evDone || evAbort || evHalt) mPend = 0;
        if (evStart) begin mPend = 1; mErr = 0; end
        if (evAbort) mErr = 1;
        if (wrEn && addr == 1 && wrData[0]) mAb = 0;
        if (wrEn && addr == 1 && wrData[1]) mHa = 0;
        if (evAbort) mAb = 1;
        if (evHalt) mHa = 1;
        if (wrEn && addr == 2) mMask = int'(wrData[3:0]);
        if (wrEn && addr == 3) mMode = int'(wrData) & 'h3D;
        if (wrEn && addr == 5) mLine = int'(wrData[3:0]);
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      string tag;
      case (addr)
        0: tag = "R2 model status";
        1: tag = "R7 model xstatus";
        2: tag = "R4 model mask";
        3: tag = "R8 model mode";
        4: tag = "R9 model xctl";
        5: tag = "R10 model line";
        default: tag = "R10 model unmapped";
      endcase
      chk(tag, rdData, modelRead(addr));
      chk("R4 model irq", irq, mIrq);
      chk("R9 model pulse", softResetPulse, mPulse);
      chk("R8 model slave flag", slaveUnsupported, mMode[3]);
    end
  end

  task automatic cyc(); @(posedge clk); #1; endtask
  task automatic wr(int a, int d);
    wrEn = 1; addr = 3'(a); wrData = 8'(d); cyc(); wrEn = 0;
  endtask
  task automatic rd(string tag, int a, int exp);
    addr = 3'(a); #1; chk(tag, rdData, exp);
  endtask

  initial begin
    #1;
    repeat (3) cyc();
    rstN = 1; cyc();
    // R1 reset values
    rd("R1 status", 0, 'h00); rd("R1 xstatus", 1, 'h40); rd("R1 mask", 2, 0);
    rd("R1 mode", 3, 0); rd("R1 xctl", 4, 0); rd("R1 line", 5, 'h0F);
    chk("R1 irq", irq, 0); chk("R1 pulse", softResetPulse, 0);
    // R3 buffer level
    bufLevel = 4; rd("R3 full", 0, 'h30);
    bufLevel = 2; rd("R3 partial", 0, 'h20);
    bufLevel = 0;
    // R2 pending / error / sticky extended bits
    evStart = 1; cyc(); evStart = 0; rd("R2 pending", 0, 'h01);
    evAbort = 1; cyc(); evAbort = 0; rd("R2 abort status", 0, 'h04);
    rd("R2 abort xstatus", 1, 'h41); chk("R4 no irq when masked", irq, 0);
    evStart = 1; cyc(); evStart = 0; rd("R2 start clears error", 0, 'h01);
    evHalt = 1; cyc(); evHalt = 0; rd("R2 halt", 0, 'h00); rd("R2 halt xstatus", 1, 'h43);
    // R7 extended status clearing and live bits
    wr(1, 'hFF); rd("R7 w1c", 1, 'h40);
    busBusy = 1; rd("R7 busy", 1, 'h10); busBusy = 0;
    // R4 gating
    wr(2, 'h0F);
    evSlave = 1; cyc(); evSlave = 0; chk("R4 global enable off", irq, 0);
    wr(3, 'h04);
    evSlave = 1; cyc(); evSlave = 0; chk("R4 raise", irq, 1); rd("R4 status bit1", 0, 'h02);
    // R6 clear semantics
    wr(0, 'hFF); rd("R6 clear all", 0, 'h00); chk("R6 irq low", irq, 0);
    evAbort = 1; cyc(); evAbort = 0; rd("R6 abort irq", 0, 'h06);
    wr(0, 'h0A); rd("R6 error kept", 0, 'h04); chk("R6 irq low 2", irq, 0);
    // R5 zero-byte done
    wr(2, 'h01);
    evDone = 1; doneBytes = 0; cyc(); evDone = 0; chk("R5 zero bytes", irq, 0);
    evDone = 1; doneBytes = 3; cyc(); evDone = 0; chk("R5 three bytes", irq, 1);
    rd("R5 status", 0, 'h06);
    // R6 enable off: line stays
    wr(3, 'h00); wr(0, 'h02); rd("R6 bit cleared", 0, 'h04); chk("R6 irq held", irq, 1);
    // R8 mode storage
    wr(3, 'hFF); rd("R8 mode mask", 3, 'h3D); chk("R8 slave flag", slaveUnsupported, 1);
    wr(0, 'h02); chk("R6 clear with enable", irq, 0);
    // R11 same-cycle raise and clear
    evDone = 1; doneBytes = 2; wr(0, 'h02); evDone = 0;
    chk("R11 irq", irq, 1); rd("R11 status", 0, 'h06);
    // R10 line control
    wr(5, 'hA5); rd("R10 line", 5, 'h05);
    // R9 flags and soft reset
    flagSet = 4'b1010; cyc(); flagSet = 0; rd("R9 flags", 4, 'hA0);
    wr(4, 'h81);
    chk("R9 pulse", softResetPulse, 1); chk("R9 irq", irq, 0);
    rd("R9 flags w1c", 4, 'h20); rd("R9 status", 0, 'h00); rd("R9 mode", 3, 0);
    rd("R9 line", 5, 'h0F); rd("R9 mask", 2, 0); rd("R9 xstatus", 1, 'h40);
    cyc(); chk("R9 pulse ends", softResetPulse, 0);
    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      wrEn = ($urandom_range(0, 3) == 0);
      addr = 3'($urandom_range(0, 7));
      wrData = 8'($urandom);
      if (addr == 4 && $urandom_range(0, 7) != 0) wrData[0] = 1'b0;
      evStart = ($urandom_range(0, 7) == 0);
      evDone = ($urandom_range(0, 7) == 0);
      doneBytes = 3'($urandom_range(0, 4));
      evAbort = ($urandom_range(0, 9) == 0);
      evHalt = ($urandom_range(0, 9) == 0);
      evSlave = ($urandom_range(0, 9) == 0);
      bufLevel = 3'($urandom_range(0, 4));
      busBusy = 1'($urandom_range(0, 1));
      flagSet = ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'h0;
      cyc();
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule